// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

This block takes one interrupt request, either a command written by the sending core as two 32-bit words or a decoded message-signalled request, and works out which local interrupt units it reaches. For each unit it holds no state of its own. Instead it reads a table of unit physical IDs, logical IDs and logical-model codes, together with a presence mask, from its inputs. One cycle after the request it presents a registered target mask, the delivery-mode code, the vector and trigger, and a strobe that says how the targets are to be signalled.

Three strobes select the action. The vector strobe means the vector is set in the request registers of the targets. The side-band strobe means SMI, NMI or INIT is raised on each target. The ID-sync strobe means each target copies its physical ID into its arbitration ID. Lowest-priority requests do not use real priority arbitration. They collapse to the lowest-numbered matching unit, which is also reported as an index. Injecting the interrupt into the cores is outside this block.

Top module: `ipi_dest_resolver`

## Requirements
- R1: Command low word fields are vector [7:0], delivery mode [10:8], logical-destination flag [11], level [14], trigger [15] and shorthand [19:18]. The destination ID is bits [31:24] of the stored high word. A low-word write produces, on the cycle after it, `res_valid` high for exactly one cycle, with `res_mode`, `res_vector` and `res_trigger` echoing the request.
- R2: A high-word write only stores the destination and produces no result. A later low-word write uses the most recently stored high word.
- R3: With the logical flag at 0, destination 0xFF selects every active unit. Any other value selects the active units whose physical ID equals it, and none if no ID matches.
- R4: With the logical flag at 1, a unit with model code 0xF matches when the destination ANDed with its logical ID is nonzero.
- R5: With the logical flag at 1, a unit with model code 0x0 matches when the upper nibbles of the destination and its logical ID are equal and the AND of the lower nibbles is nonzero. Other model codes never match.
- R6: Active units are those from unit 0 up to, but not including, the first unit whose presence bit is 0. No unit at or beyond that gap is ever targeted.
- R7: Shorthand 1 targets only unit `self_idx`. Shorthand 2 targets all active units. Shorthand 3 targets all active units except `self_idx`. Shorthand 0 uses the destination.
- R8: Mode 0 (fixed) returns the full target mask and raises `res_vec_set` when that mask is nonzero.
- R9: Mode 1 (lowest priority) returns a one-hot mask of the lowest-numbered matching unit, puts that unit's index on `res_lp_idx`, and raises `res_vec_set` if any unit matched.
- R10: Modes 2 (SMI), 4 (NMI) and 5 (INIT, other than the R11 case) return the target mask and raise `res_side_sig`, never `res_vec_set`, when the mask is nonzero.
- R11: A command in mode 5 with level 0 and trigger 1 raises `res_id_sync` with the target mask, and raises neither of the other strobes.
- R12: Modes 3, 6 and 7 still pulse `res_valid`, but give a zero mask and no strobe.
- R13: A message request uses `msg_*` fields with no shorthand, and an INIT message is always side-band. When a command and a message arrive in the same cycle, the command is resolved and the message is discarded.
- R14: During reset, `res_valid`, all strobes and the mask are 0, and the stored destination is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lo_wr | input | 1 | Low command word write; starts resolution |
| cmd_hi_wr | input | 1 | High command word write; stores destination |
| cmd_wdata | input | 32 | Command write data |
| msg_valid | input | 1 | Message-signalled request strobe |
| msg_dest | input | 8 | Message destination ID |
| msg_logical | input | 1 | Message logical-destination flag |
| msg_mode | input | 3 | Message delivery mode |
| msg_vector | input | 8 | Message vector |
| msg_trigger | input | 1 | Message trigger (1 = level) |
| self_idx | input | IDX_W | Index of the sending unit |
| unit_present | input | NUM_UNITS | Presence bit per unit |
| unit_phys_id | input | NUM_UNITS*8 | Physical ID per unit, unit i at [8i+7:8i] |
| unit_log_id | input | NUM_UNITS*8 | Logical ID per unit |
| unit_model | input | NUM_UNITS*4 | Logical model code per unit |
| res_valid | output | 1 | Result valid, one cycle per request |
| res_mask | output | NUM_UNITS | Target mask |
| res_mode | output | 3 | Delivery mode echoed |
| res_vector | output | 8 | Vector echoed |
| res_trigger | output | 1 | Trigger echoed |
| res_vec_set | output | 1 | Set vector in targets |
| res_side_sig | output | 1 | Raise SMI/NMI/INIT on targets |
| res_id_sync | output | 1 | Load arbitration ID from physical ID |
| res_lp_idx | output | IDX_W | Lowest-priority chosen unit |

## Verification
The bench builds the block with eight units. At that size every bit of the target mask can be predicted by hand, and a single absent unit in slot 6 followed by a present unit in slot 7 exercises the gap cutoff. The table gives units 0–2 the flat model and units 3–5 the cluster model, so that one logical destination can hit both kinds at once. Setting `self_idx` to 2 makes the self-only and all-but-self shorthands produce clearly distinct masks.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD3  = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam int ID_W          = 8;
    localparam int MODEL_W       = 4;
    localparam int MODE_LSB      = 8;
    localparam int LOGICAL_BIT   = 11;
    localparam int LEVEL_BIT     = 14;
    localparam int TRIG_BIT      = 15;
    localparam int SH_LSB        = 18;
    localparam int DEST_LSB      = 24;
    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [7:0] DEST_BCAST    = 8'hFF;

    typedef struct packed {
        logic [7:0] vector;
        dmode_e     mode;
        logic       logical;
        logic       level;
        logic       trigger;
        shorthand_e sh;
        logic [7:0] dest;
        logic       from_cmd;
    } req_t;

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
    import ipi_pkg::*;
#(
    parameter int NUM_UNITS = 255,
    localparam int IDX_W = $clog2(NUM_UNITS)
) (
    input  req_t                        req,
    input  logic [IDX_W-1:0]            self_idx,
    input  logic [NUM_UNITS-1:0]        unit_present,
    input  logic [NUM_UNITS*ID_W-1:0]   unit_phys_id,
    input  logic [NUM_UNITS*ID_W-1:0]   unit_log_id,
    input  logic [NUM_UNITS*MODEL_W-1:0] unit_model,
    output logic [NUM_UNITS-1:0]        match
);

    logic [NUM_UNITS-1:0] active;

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        logic [ID_W-1:0]    pid;
        logic [ID_W-1:0]    lid;
        logic [MODEL_W-1:0] mdl;
        logic               phys_hit;
        logic               flat_hit;
        logic               clus_hit;
        logic               addr_hit;
        logic               sel;

        if (i == 0) begin : g_first
            assign active[i] = unit_present[i];
        end else begin : g_rest
            assign active[i] = active[i-1] & unit_present[i];
        end

        assign pid = unit_phys_id[i*ID_W +: ID_W];
        assign lid = unit_log_id[i*ID_W +: ID_W];
        assign mdl = unit_model[i*MODEL_W +: MODEL_W];

        assign phys_hit = (req.dest == DEST_BCAST) || (pid == req.dest);
        assign flat_hit = (mdl == MODEL_FLAT) && ((req.dest & lid) != '0);
        assign clus_hit = (mdl == MODEL_CLUSTER) &&
                          (req.dest[7:4] == lid[7:4]) &&
                          ((req.dest[3:0] & lid[3:0]) != '0);
        assign addr_hit = req.logical ? (flat_hit | clus_hit) : phys_hit;

        always_comb begin
            case (req.sh)
                SH_SELF:   sel = (self_idx == IDX_W'(i));
                SH_ALL:    sel = 1'b1;
                SH_OTHERS: sel = (self_idx != IDX_W'(i));
                default:   sel = addr_hit;
            endcase
        end

        assign match[i] = active[i] & sel;
    end

endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
    parameter int NUM_UNITS = 255,
    localparam int IDX_W = $clog2(NUM_UNITS)
) (
    input  logic [NUM_UNITS-1:0] mask,
    output logic [NUM_UNITS-1:0] onehot,
    output logic [IDX_W-1:0]     idx,
    output logic                 any
);

    always_comb begin
        idx    = '0;
        onehot = '0;
        any    = |mask;
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IDX_W'(i);
            end
        end
        if (any) begin
            onehot[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_pkg::*;
#(
    parameter int NUM_UNITS = 255,
    localparam int IDX_W = $clog2(NUM_UNITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_lo_wr,
    input  logic                          cmd_hi_wr,
    input  logic [31:0]                   cmd_wdata,
    input  logic                          msg_valid,
    input  logic [7:0]                    msg_dest,
    input  logic                          msg_logical,
    input  logic [2:0]                    msg_mode,
    input  logic [7:0]                    msg_vector,
    input  logic                          msg_trigger,
    input  logic [IDX_W-1:0]              self_idx,
    input  logic [NUM_UNITS-1:0]          unit_present,
    input  logic [NUM_UNITS*8-1:0]        unit_phys_id,
    input  logic [NUM_UNITS*8-1:0]        unit_log_id,
    input  logic [NUM_UNITS*4-1:0]        unit_model,
    output logic                          res_valid,
    output logic [NUM_UNITS-1:0]          res_mask,
    output logic [2:0]                    res_mode,
    output logic [7:0]                    res_vector,
    output logic                          res_trigger,
    output logic                          res_vec_set,
    output logic                          res_side_sig,
    output logic                          res_id_sync,
    output logic [IDX_W-1:0]              res_lp_idx
);

    typedef struct packed {
        logic [7:0]           hi_dest;
        logic                 valid;
        logic [NUM_UNITS-1:0] mask;
        logic [2:0]           mode;
        logic [7:0]           vector;
        logic                 trigger;
        logic                 vec_set;
        logic                 side_sig;
        logic                 id_sync;
        logic [IDX_W-1:0]     lp_idx;
    } state_t;

    state_t st_d, st_q;
    req_t   req;
    logic   start;

    logic [NUM_UNITS-1:0] match;
    logic [NUM_UNITS-1:0] lp_onehot;
    logic [IDX_W-1:0]     lp_idx;
    logic                 lp_any;
    logic                 any_match;
    logic                 unused_bits;

    assign unused_bits = ^{cmd_wdata[23:20], cmd_wdata[17:16], cmd_wdata[13:12]};

    // request selection: a command write wins over a message in the same cycle
    always_comb begin
        req   = '0;
        start = cmd_lo_wr | msg_valid;
        if (cmd_lo_wr) begin
            req.vector   = cmd_wdata[7:0];
            req.mode     = dmode_e'(cmd_wdata[MODE_LSB +: 3]);
            req.logical  = cmd_wdata[LOGICAL_BIT];
            req.level    = cmd_wdata[LEVEL_BIT];
            req.trigger  = cmd_wdata[TRIG_BIT];
            req.sh       = shorthand_e'(cmd_wdata[SH_LSB +: 2]);
            req.dest     = st_q.hi_dest;
            req.from_cmd = 1'b1;
        end else if (msg_valid) begin
            req.vector   = msg_vector;
            req.mode     = dmode_e'(msg_mode);
            req.logical  = msg_logical;
            req.level    = 1'b1;
            req.trigger  = msg_trigger;
            req.sh       = SH_NONE;
            req.dest     = msg_dest;
            req.from_cmd = 1'b0;
        end
    end

    ipi_unit_match #(.NUM_UNITS(NUM_UNITS)) u_match (
        .req          (req),
        .self_idx     (self_idx),
        .unit_present (unit_present),
        .unit_phys_id (unit_phys_id),
        .unit_log_id  (unit_log_id),
        .unit_model   (unit_model),
        .match        (match)
    );

    ipi_lowest_pick #(.NUM_UNITS(NUM_UNITS)) u_pick (
        .mask   (match),
        .onehot (lp_onehot),
        .idx    (lp_idx),
        .any    (lp_any)
    );

    assign any_match = |match;

    always_comb begin
        st_d         = '0;
        st_d.hi_dest = (cmd_hi_wr && !cmd_lo_wr) ? cmd_wdata[DEST_LSB +: 8] : st_q.hi_dest;
        if (start) begin
            st_d.valid   = 1'b1;
            st_d.mode    = req.mode;
            st_d.vector  = req.vector;
            st_d.trigger = req.trigger;
            case (req.mode)
                DM_FIXED: begin
                    st_d.mask    = match;
                    st_d.vec_set = any_match;
                end
                DM_LOWEST: begin
                    st_d.mask    = lp_onehot;
                    st_d.vec_set = lp_any;
                    st_d.lp_idx  = lp_idx;
                end
                DM_SMI, DM_NMI: begin
                    st_d.mask     = match;
                    st_d.side_sig = any_match;
                end
                DM_INIT: begin
                    st_d.mask = match;
                    if (req.from_cmd && !req.level && req.trigger) begin
                        st_d.id_sync = any_match;
                    end else begin
                        st_d.side_sig = any_match;
                    end
                end
                default: begin
                    st_d.mask = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid    = st_q.valid;
    assign res_mask     = st_q.mask;
    assign res_mode     = st_q.mode;
    assign res_vector   = st_q.vector;
    assign res_trigger  = st_q.trigger;
    assign res_vec_set  = st_q.vec_set;
    assign res_side_sig = st_q.side_sig;
    assign res_id_sync  = st_q.id_sync;
    assign res_lp_idx   = st_q.lp_idx;

endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
    parameter int NUM_UNITS = 255,
    localparam int IDX_W = $clog2(NUM_UNITS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_lo_wr,
    input logic                 msg_valid,
    input logic [NUM_UNITS-1:0] unit_present,
    input logic                 res_valid,
    input logic [NUM_UNITS-1:0] res_mask,
    input logic [2:0]           res_mode,
    input logic                 res_vec_set,
    input logic                 res_side_sig,
    input logic                 res_id_sync,
    input logic [IDX_W-1:0]     res_lp_idx
);

    logic                 seen_q;
    logic                 req_q;
    logic [NUM_UNITS-1:0] pres_q;
    logic [NUM_UNITS-1:0] allowed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            req_q  <= 1'b0;
            pres_q <= '0;
        end else begin
            seen_q <= 1'b1;
            req_q  <= cmd_lo_wr | msg_valid;
            pres_q <= unit_present;
        end
    end

    always_comb begin
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_UNITS; i++) begin
            ok         = ok & pres_q[i];
            allowed[i] = ok;
        end
    end

    // R1
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (res_valid == req_q));

    // R6
    gap_cutoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && res_valid) |-> ((res_mask & ~allowed) == '0));

    // R8
    strobe_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vec_set || res_side_sig || res_id_sync) |-> (res_valid && (res_mask != '0)));

    // R9
    lowest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mode == 3'd1 && res_vec_set) |->
            ($countones(res_mask) == 1 && res_mask[res_lp_idx]));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_vec_set, res_side_sig, res_id_sync}));

    // R11
    sync_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_id_sync |-> (res_mode == 3'd5));

    // R12
    drop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_mode == 3'd3 || res_mode == 3'd6 || res_mode == 3'd7)) |->
            (res_mask == '0 && !res_vec_set && !res_side_sig && !res_id_sync));

endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_lo_wr    (cmd_lo_wr),
    .msg_valid    (msg_valid),
    .unit_present (unit_present),
    .res_valid    (res_valid),
    .res_mask     (res_mask),
    .res_mode     (res_mode),
    .res_vec_set  (res_vec_set),
    .res_side_sig (res_side_sig),
    .res_id_sync  (res_id_sync),
    .res_lp_idx   (res_lp_idx)
);

// File: tb/ipi_dest_resolver_test.sv
module ipi_dest_resolver_test;

    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_lo_wr = 1'b0;
    logic          cmd_hi_wr = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic          msg_valid = 1'b0;
    logic [7:0]    msg_dest = '0;
    logic          msg_logical = 1'b0;
    logic [2:0]    msg_mode = '0;
    logic [7:0]    msg_vector = '0;
    logic          msg_trigger = 1'b0;
    logic [IW-1:0] self_idx = 3'd2;
    logic [N-1:0]  unit_present = 8'b1011_1111;
    logic [N*8-1:0] unit_phys_id = {8'h27, 8'h26, 8'h25, 8'h24, 8'h23, 8'h22, 8'h21, 8'h20};
    logic [N*8-1:0] unit_log_id  = {8'hFF, 8'h00, 8'h41, 8'h32, 8'h31, 8'h04, 8'h02, 8'h01};
    logic [N*4-1:0] unit_model   = {4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF};

    logic          res_valid;
    logic [N-1:0]  res_mask;
    logic [2:0]    res_mode;
    logic [7:0]    res_vector;
    logic          res_trigger;
    logic          res_vec_set;
    logic          res_side_sig;
    logic          res_id_sync;
    logic [IW-1:0] res_lp_idx;

    ipi_dest_resolver #(.NUM_UNITS(N)) uut (.*);

    always #5 clk = ~clk;

    typedef struct packed {
        logic [N-1:0]  mask;
        logic [2:0]    mode;
        logic [7:0]    vec;
        logic          trig;
        logic          vs;
        logic          sd;
        logic          sy;
        logic [IW-1:0] lp;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_w(input logic [7:0] vec, input logic [2:0] mode,
                                         input logic lg, input logic lvl, input logic trg,
                                         input logic [1:0] sh);
        return {12'h0, sh, 2'b00, trg, lvl, 2'b00, lg, mode, vec};
    endfunction

    function automatic exp_t mk(input logic [N-1:0] m, input logic [2:0] md, input logic [7:0] v,
                                input logic t, input logic vs, input logic sd, input logic sy,
                                input logic [IW-1:0] lp);
        exp_t e;
        e = '{mask: m, mode: md, vec: v, trig: t, vs: vs, sd: sd, sy: sy, lp: lp};
        return e;
    endfunction

    // monitor: every result pops one expected item
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t a;
            a = '{mask: res_mask, mode: res_mode, vec: res_vector, trig: res_trigger,
                  vs: res_vec_set, sd: res_side_sig, sy: res_id_sync, lp: res_lp_idx};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected result", 64'(a), 64'd0);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(a == e, t, 64'(a), 64'(e));
            end
        end
    end

    task automatic wr_hi(input logic [7:0] dest);
        @(negedge clk);
        cmd_hi_wr = 1'b1;
        cmd_wdata = {dest, 24'h0};
        @(negedge clk);
        cmd_hi_wr = 1'b0;
        cmd_wdata = '0;
        chk(res_valid == 1'b0, "R2 high write gave result", 64'(res_valid), 64'd0);
    endtask

    task automatic wr_lo(input logic [31:0] lo, input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_lo_wr = 1'b1;
        cmd_wdata = lo;
        @(negedge clk);
        cmd_lo_wr = 1'b0;
        cmd_wdata = '0;
    endtask

    task automatic send(input logic [7:0] dest, input logic [31:0] lo, input exp_t e, input string tag);
        wr_hi(dest);
        wr_lo(lo, e, tag);
    endtask

    task automatic send_msg(input logic [7:0] d, input logic lg, input logic [2:0] md,
                            input logic [7:0] v, input logic t, input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        msg_valid = 1'b1; msg_dest = d; msg_logical = lg;
        msg_mode = md; msg_vector = v; msg_trigger = t;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R14 reset state
        chk(res_valid == 0 && res_mask == 0 && !res_vec_set && !res_side_sig && !res_id_sync,
            "R14 reset outputs", {res_valid, res_mask}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // physical
        send(8'h23, lo_w(8'h40, 3'd0, 0, 1, 0, 2'd0), mk(8'h08, 0, 8'h40, 0, 1, 0, 0, 0), "R3 physical id");
        send(8'hFF, lo_w(8'h41, 3'd0, 0, 1, 1, 2'd0), mk(8'h3F, 0, 8'h41, 1, 1, 0, 0, 0), "R3 broadcast R8");
        send(8'h27, lo_w(8'h42, 3'd0, 0, 1, 0, 2'd0), mk(8'h00, 0, 8'h42, 0, 0, 0, 0, 0), "R6 beyond gap");
        send(8'h99, lo_w(8'h43, 3'd0, 0, 1, 0, 2'd0), mk(8'h00, 0, 8'h43, 0, 0, 0, 0, 0), "R3 no match");
        // logical
        send(8'h05, lo_w(8'h50, 3'd0, 1, 1, 0, 2'd0), mk(8'h05, 0, 8'h50, 0, 1, 0, 0, 0), "R4 flat");
        send(8'h33, lo_w(8'h51, 3'd0, 1, 1, 0, 2'd0), mk(8'h1B, 0, 8'h51, 0, 1, 0, 0, 0), "R5 cluster mixed");
        send(8'h41, lo_w(8'h52, 3'd0, 1, 1, 0, 2'd0), mk(8'h21, 0, 8'h52, 0, 1, 0, 0, 0), "R5 cluster 4");
        // lowest priority
        send(8'h06, lo_w(8'h60, 3'd1, 1, 1, 0, 2'd0), mk(8'h02, 1, 8'h60, 0, 1, 0, 0, 3'd1), "R9 lowest logical");
        send(8'hFF, lo_w(8'h61, 3'd1, 0, 1, 0, 2'd0), mk(8'h01, 1, 8'h61, 0, 1, 0, 0, 3'd0), "R9 lowest bcast");
        // shorthands
        send(8'h99, lo_w(8'h55, 3'd0, 0, 1, 0, 2'd1), mk(8'h04, 0, 8'h55, 0, 1, 0, 0, 0), "R7 self");
        send(8'h99, lo_w(8'h56, 3'd0, 0, 1, 0, 2'd2), mk(8'h3F, 0, 8'h56, 0, 1, 0, 0, 0), "R7 all");
        send(8'h99, lo_w(8'h57, 3'd0, 0, 1, 0, 2'd3), mk(8'h3B, 0, 8'h57, 0, 1, 0, 0, 0), "R7 others");
        // side-band
        send(8'h21, lo_w(8'h00, 3'd4, 0, 1, 0, 2'd0), mk(8'h02, 4, 8'h00, 0, 0, 1, 0, 0), "R10 nmi");
        send(8'h33, lo_w(8'h00, 3'd2, 1, 1, 0, 2'd0), mk(8'h1B, 2, 8'h00, 0, 0, 1, 0, 0), "R10 smi");
        send(8'h20, lo_w(8'h00, 3'd5, 0, 1, 0, 2'd0), mk(8'h01, 5, 8'h00, 0, 0, 1, 0, 0), "R10 init");
        send(8'h00, lo_w(8'h00, 3'd5, 0, 0, 1, 2'd2), mk(8'h3F, 5, 8'h00, 1, 0, 0, 1, 0), "R11 id sync");
        // dropped
        send(8'hFF, lo_w(8'h70, 3'd7, 0, 1, 0, 2'd0), mk(8'h00, 7, 8'h70, 0, 0, 0, 0, 0), "R12 extint");
        send(8'hFF, lo_w(8'h71, 3'd3, 0, 1, 0, 2'd0), mk(8'h00, 3, 8'h71, 0, 0, 0, 0, 0), "R12 mode3");
        // stored high word reused
        wr_hi(8'h22);
        repeat (2) @(negedge clk);
        wr_lo(lo_w(8'h44, 3'd0, 0, 1, 0, 2'd0), mk(8'h04, 0, 8'h44, 0, 1, 0, 0, 0), "R2 stored dest");
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 single cycle", 64'(res_valid), 64'd0);
        // message path
        send_msg(8'h24, 0, 3'd0, 8'h61, 1, mk(8'h10, 0, 8'h61, 1, 1, 0, 0, 0), "R13 msg fixed");
        send_msg(8'h01, 1, 3'd5, 8'h00, 1, mk(8'h01, 5, 8'h00, 1, 0, 1, 0, 0), "R13 msg init");
        // command and message together
        wr_hi(8'h25);
        exp_q.push_back(mk(8'h20, 0, 8'h48, 0, 1, 0, 0, 0));
        tag_q.push_back("R13 cmd priority");
        @(negedge clk);
        cmd_lo_wr = 1'b1; cmd_wdata = lo_w(8'h48, 3'd0, 0, 1, 0, 2'd0);
        msg_valid = 1'b1; msg_dest = 8'h20; msg_mode = 3'd4; msg_logical = 1'b0;
        @(negedge clk);
        cmd_lo_wr = 1'b0; cmd_wdata = '0; msg_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all results seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule